// File: doc/BRIEF.md
# AC Sampling Input Boundary Cell

This block is a bank of boundary-scan cells placed on system input pins. Each cell can report either the static level on its pin or a value recovered from an AC toggle pattern arriving on that pin. When a net is capacitor-coupled, the receiver never sees a steady level, only a pattern that alternates. To recover the preloaded logic value, each cell has a dedicated sample register that takes a snapshot of the pin on a sync strobe. An external sequencer fires that strobe once every sixteenth pattern-clock cycle, on the falling phase of the pattern clock. Because sixteen is even, the toggle pattern is back at its seeded phase at each strobe, so the sampled bit equals the value the driving cell was seeded with.

A test-ran flag selects the capture source for every cell. When the flag is high, the capture stage loads from the sample register. When it is low, the capture stage loads straight from the pin, and the bank behaves as a plain DC boundary-scan register. The capture stages form one serial chain from the scan input to the scan output. A separate update stage holds the value presented to the system logic while the mode select is in test mode. All registers run on one test clock and use written-out enables: one for capture or shift, one for update, and the sync strobe for sampling.

Top module: `acb_input_bank`

## Requirements
- R1: While reset is asserted and immediately after it, every sample, capture and update register reads 0, so `scan_out` is 0, a full shift yields all zeros, and `sys_out` is 0 in test mode.
- R2: A cell's sample register loads that cell's pin on a clock edge where `ac_sync` is 1, and holds its value on every edge where `ac_sync` is 0, whatever the pin does.
- R3: On an edge with `clock_dr`=1, `shift_dr`=0 and `ac_ran`=1, each capture stage loads the decoded sample, which equals the sampled bit unchanged. The current pin level has no effect on that load.
- R4: On an edge with `clock_dr`=1, `shift_dr`=0 and `ac_ran`=0, each capture stage loads its current pin level, and the sample register has no effect on that load.
- R5: On an edge with `clock_dr`=1 and `shift_dr`=1, the chain moves one place toward `scan_out`: cell 0 takes `scan_in`, and cell k takes the old value of cell k-1. `scan_out` is the capture stage of cell NUM_PINS-1, so a word shifted in MSB first lands with bit k in cell k.
- R6: On an edge with `update_dr`=1, each update stage copies its capture stage. On all other edges it holds, including edges where the chain shifts.
- R7: `sys_out[k]` equals the update stage of cell k when `mode_test`=1, and equals `pin_in[k]` when `mode_test`=0.
- R8: On any edge with `clock_dr`=0, the capture stages hold their values, whatever the pins do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low test-logic reset |
| pin_in | input | NUM_PINS | System input pin levels, bit k for cell k |
| sys_out | output | NUM_PINS | Data delivered to the system logic |
| scan_in | input | 1 | Serial data into cell 0 |
| scan_out | output | 1 | Serial data out of cell NUM_PINS-1 |
| shift_dr | input | 1 | 1 selects shift, 0 selects capture, when clock_dr is 1 |
| clock_dr | input | 1 | Enable for the capture/shift stages |
| update_dr | input | 1 | Enable for the update stages |
| mode_test | input | 1 | 1 drives sys_out from the update stages, 0 passes the pins |
| ac_sync | input | 1 | Sample strobe for the sample registers |
| ac_ran | input | 1 | Capture source: 1 sample register, 0 pin |

## Verification
Sample, capture, shift and update results are each visible one clock edge after the cycle that enables them. `sys_out` follows `mode_test` and the pins within the same cycle. The bench applies inputs at the falling edge, lets one rising edge act on them, and samples at the next falling edge. Capture results are read by shifting the chain out. Before each shift edge the bench reads `scan_out`, so cell NUM_PINS-1-i is observed at step i. A full sweep of the 16 patterns on a four-pin bank moves the pins between strobe and capture, which separates the sampled value from the live level.

// File: rtl/acb_pkg.sv
package acb_pkg;

  // Source selected for a capture-stage load
  typedef enum logic {
    CAP_FROM_PIN    = 1'b0,
    CAP_FROM_SAMPLE = 1'b1
  } acb_cap_src_e;

  // Per-cycle scan controls shared by every cell
  typedef struct packed {
    logic clock_en;
    logic shift_sel;
    logic update_en;
  } acb_scan_ctrl_t;

endpackage

// File: rtl/acb_sample_stage.sv
module acb_sample_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic pin_bit,
  output logic decoded_bit
);

  logic sample_q;
  logic sample_d;

  // Strobe is the clock enable of the sample register
  always_comb begin
    sample_d = sample_q;
    if (strobe) begin
      sample_d = pin_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q <= 1'b0;
    end else begin
      sample_q <= sample_d;
    end
  end

  // Even strobe spacing returns the toggle pattern to its seed phase,
  // so the decoded logic value is the sampled bit itself.
  assign decoded_bit = sample_q;

  AST_SAMPLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (decoded_bit == $past(pin_bit))); // R2

  AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(decoded_bit)); // R2

endmodule

// File: rtl/acb_scan_stage.sv
module acb_scan_stage
  import acb_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  acb_scan_ctrl_t ctrl,
  input  acb_cap_src_e   cap_src,
  input  logic           pin_bit,
  input  logic           ac_bit,
  input  logic           ser_in,
  output logic           cap_q,
  output logic           upd_q
);

  logic cap_d;
  logic upd_d;
  logic capture_bit;

  // Capture-source selection
  always_comb begin
    case (cap_src)
      CAP_FROM_SAMPLE: capture_bit = ac_bit;
      default:         capture_bit = pin_bit;
    endcase
  end

  always_comb begin
    cap_d = cap_q;
    if (ctrl.clock_en) begin
      cap_d = ctrl.shift_sel ? ser_in : capture_bit;
    end
  end

  always_comb begin
    upd_d = upd_q;
    if (ctrl.update_en) begin
      upd_d = cap_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      cap_q <= cap_d;
      upd_q <= upd_d;
    end
  end

  AST_CAP_FROM_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.clock_en && !ctrl.shift_sel && cap_src == CAP_FROM_SAMPLE)
      |=> (cap_q == $past(ac_bit))); // R3

  AST_CAP_FROM_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.clock_en && !ctrl.shift_sel && cap_src == CAP_FROM_PIN)
      |=> (cap_q == $past(pin_bit))); // R4

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.clock_en && ctrl.shift_sel) |=> (cap_q == $past(ser_in))); // R5

  AST_UPDATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.update_en |=> $stable(upd_q)); // R6

  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.clock_en |=> $stable(cap_q)); // R8

endmodule

// File: rtl/acb_pin_cell.sv
module acb_pin_cell
  import acb_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  acb_scan_ctrl_t ctrl,
  input  acb_cap_src_e   cap_src,
  input  logic           mode_test,
  input  logic           ac_sync,
  input  logic           pin_bit,
  input  logic           ser_in,
  output logic           ser_out,
  output logic           sys_bit
);

  logic decoded_bit;
  logic upd_bit;

  acb_sample_stage u_sample (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (ac_sync),
    .pin_bit     (pin_bit),
    .decoded_bit (decoded_bit)
  );

  acb_scan_stage u_scan (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl    (ctrl),
    .cap_src (cap_src),
    .pin_bit (pin_bit),
    .ac_bit  (decoded_bit),
    .ser_in  (ser_in),
    .cap_q   (ser_out),
    .upd_q   (upd_bit)
  );

  // Drive toward system logic: pin in functional mode, update stage in test mode
  assign sys_bit = mode_test ? upd_bit : pin_bit;

endmodule

// File: rtl/acb_input_bank.sv
module acb_input_bank
  import acb_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] sys_out,
  input  logic                scan_in,
  output logic                scan_out,
  input  logic                shift_dr,
  input  logic                clock_dr,
  input  logic                update_dr,
  input  logic                mode_test,
  input  logic                ac_sync,
  input  logic                ac_ran
);

  localparam int LAST_CELL = NUM_PINS - 1;

  acb_scan_ctrl_t ctrl;
  acb_cap_src_e   cap_src;
  logic [NUM_PINS:0] chain;

  always_comb begin
    ctrl.clock_en  = clock_dr;
    ctrl.shift_sel = shift_dr;
    ctrl.update_en = update_dr;
    cap_src        = ac_ran ? CAP_FROM_SAMPLE : CAP_FROM_PIN;
  end

  assign chain[0] = scan_in;

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_cell
    acb_pin_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl      (ctrl),
      .cap_src   (cap_src),
      .mode_test (mode_test),
      .ac_sync   (ac_sync),
      .pin_bit   (pin_in[k]),
      .ser_in    (chain[k]),
      .ser_out   (chain[k+1]),
      .sys_bit   (sys_out[k])
    );
  end

  assign scan_out = chain[LAST_CELL+1];

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (!rst_n || !scan_out)); // R1

  AST_FUNC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_test |-> (sys_out == pin_in)); // R7

endmodule

// File: tb/tb_acb_input_bank.sv
module tb_acb_input_bank;

  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] pin_in;
  logic [N-1:0] sys_out;
  logic         scan_in, scan_out;
  logic         shift_dr, clock_dr, update_dr, mode_test, ac_sync, ac_ran;

  int checks = 0;
  int fails  = 0;
  logic [N-1:0] upd_model;

  acb_input_bank #(.NUM_PINS(N)) dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .sys_out(sys_out),
    .scan_in(scan_in), .scan_out(scan_out), .shift_dr(shift_dr),
    .clock_dr(clock_dr), .update_dr(update_dr), .mode_test(mode_test),
    .ac_sync(ac_sync), .ac_ran(ac_ran)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Shift the chain N times, loading word s (bit k ends in cell k); returns captured word
  task automatic shift_word(input logic [N-1:0] s, output logic [N-1:0] got);
    got = '0;
    for (int i = 0; i < N; i++) begin
      got[N-1-i] = scan_out;
      scan_in  = s[N-1-i];
      shift_dr = 1'b1;
      clock_dr = 1'b1;
      cyc();
    end
    shift_dr = 1'b0;
    clock_dr = 1'b0;
    scan_in  = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [N-1:0] got;
    logic [N-1:0] s;
    rst_n = 1'b0; pin_in = '0; scan_in = 1'b0; shift_dr = 1'b0; clock_dr = 1'b0;
    update_dr = 1'b0; mode_test = 1'b1; ac_sync = 1'b0; ac_ran = 1'b0;
    upd_model = '0;
    cyc(); cyc();
    check("R1 scan_out in reset", {7'd0, scan_out}, 8'd0);
    check("R1 sys_out in reset", {4'd0, sys_out}, 8'd0);
    rst_n = 1'b1;
    cyc();
    check("R1 sys_out after reset", {4'd0, sys_out}, 8'd0);
    shift_word('0, got);
    check("R1 chain after reset", {4'd0, got}, 8'd0);

    for (int a = 0; a < 16; a++) begin
      logic [N-1:0] av;
      av = a[N-1:0];
      // R2: strobe the sample registers, then move the pins away
      pin_in = av; ac_sync = 1'b1;
      cyc();
      ac_sync = 1'b0; pin_in = ~av;
      cyc(); cyc();
      // R3: capture from the sample registers
      clock_dr = 1'b1; shift_dr = 1'b0; ac_ran = 1'b1;
      cyc();
      clock_dr = 1'b0; ac_ran = 1'b0;
      s = av ^ 4'h5;
      shift_word(s, got);
      check("R2 R3 sampled value captured", {4'd0, got}, {4'd0, av});
      mode_test = 1'b1;
      #1;
      check("R6 update holds across shift", {4'd0, sys_out}, {4'd0, upd_model});
      // R6 R5: update exposes the shifted word
      update_dr = 1'b1;
      cyc();
      update_dr = 1'b0;
      upd_model = s;
      check("R5 R6 R7 shifted word updated", {4'd0, sys_out}, {4'd0, s});
      mode_test = 1'b0;
      #1;
      check("R7 pin passthrough", {4'd0, sys_out}, {4'd0, ~av});
      mode_test = 1'b1;
      // R4: capture straight from the pin
      clock_dr = 1'b1; ac_ran = 1'b0;
      cyc();
      clock_dr = 1'b0;
      // R8: pins move while capture is disabled
      pin_in = av;
      cyc(); cyc();
      shift_word('0, got);
      check("R4 R8 pin value captured and held", {4'd0, got}, {4'd0, ~av});
      check("R6 update held during shifts", {4'd0, sys_out}, {4'd0, upd_model});
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule